// File: doc/BRIEF.md
# Paged Logical-to-Physical Address Translator

This block is the address translation stage of a memory controller. It maps a 25-bit logical address space onto 128 physical RAM pages. Software fills a 128-slot table by writing packed entry words. Each entry word carries three things: the physical page it describes, the logical page that maps onto that physical page, and a two-bit protection level. A separate control write picks the page size: 4, 8, 16 or 32 KB.

Entries are stored raw. They are unpacked at lookup time using the page size in force at that moment, so a change of page size needs no rewrite of the table. Both the physical page number and the logical page number are scattered across the entry word. How they are scattered depends on the page size.

A lookup presents a logical address, an access width, a processor mode and a read/write flag. All 128 entries are compared against it in parallel. One cycle later the block returns a physical address, a hit flag and a fault flag.

Top module: `xlat_top`

## Requirements
- R1: After reset every table slot is invalid, the page size is 4 KB, and the result outputs are zero. A lookup made before any table write misses and faults.
- R2: A table write stores the whole entry word at slot index word[6:0] and marks that slot valid. A later write to the same slot replaces the earlier one.
- R3: With 4 KB pages, the physical page is word[6:0]. The logical page is {word[11:10], word[22:12]}, compared against address[24:12].
- R4: With 8 KB pages, the physical page is {word[0], word[6:1]}. The logical page is {word[11:10], word[22:13]}, compared against address[24:13].
- R5: With 16 KB pages, the physical page is {word[1:0], word[6:2]}. The logical page is {word[11:10], word[22:14]}, compared against address[24:14].
- R6: With 32 KB pages, the physical page is {word[1], word[2], word[0], word[6:3]}. The logical page is {word[11:10], word[22:15]}, compared against address[24:15].
- R7: A control write sets the page size from its address bits [3:2]: 0 selects 4 KB, 1 selects 8 KB, 2 selects 16 KB and 3 selects 32 KB. Later lookups decode the entries already stored using the new size.
- R8: On a hit, the physical address is the physical page shifted left by log2(page size), OR'd with the in-page offset of the logical address. A word-sized lookup clears address bits [1:0] before matching and before forming the offset.
- R9: A lookup that matches no valid slot returns hit 0, fault 1 and a physical address of 0.
- R10: When several valid slots match, the slot with the lowest index supplies the result.
- R11: Entry bits [9:8] hold a protection level. A user-mode hit with level 0 never faults. Level 1 faults only on writes. Levels 2 and 3 always fault. A supervisor-mode hit never faults. A hit that faults still reports hit 1 and its physical address.
- R12: A result appears exactly one cycle after the lookup is presented, with rs_valid high. rs_valid is low, and the result fields are zero, in the cycle after a cycle with no lookup. A table or control write in the same cycle as a lookup is not seen by that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_addr | input | 2 | Control write address bits [3:2], the page-size code |
| tbl_we | input | 1 | Translator table write strobe |
| tbl_word | input | 23 | Packed entry word; bits [6:0] also give the slot |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 25 | Logical address |
| lk_word | input | 1 | 1 = word-sized access |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| lk_write | input | 1 | 1 = write access |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A valid slot matched |
| rs_fault | output | 1 | Miss or protection violation |
| rs_paddr | output | 22 | Physical address |

## Verification
A lookup can share its cycle with a table write or with a page-size change. In both cases the lookup must see the state as it stood before the write. The bench provokes this in two ways. Directed steps write a fresh entry and, in the same cycle, look up the logical page that entry names. They also switch the page size in the same cycle as a lookup. The random phase overlaps writes and lookups freely. A reference model judges every result: it evaluates each lookup before applying that cycle's writes, so a miss is expected in the colliding cycle and a hit in the one after.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int ENTRIES   = 128;
    parameter int IDX_W     = $clog2(ENTRIES);
    parameter int ENTRY_W   = 23;
    parameter int LADDR_W   = 25;
    parameter int PPN_W     = 7;
    parameter int LPN_W     = 13;
    parameter int MIN_SHIFT = 12;
    parameter int MAX_SHIFT = 15;
    parameter int PADDR_W   = PPN_W + MAX_SHIFT;
    parameter int PROT_LO   = 8;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_8K  = 2'd1,
        PG_16K = 2'd2,
        PG_32K = 2'd3
    } pg_size_e;

    // logical page held in an entry word, right-aligned
    function automatic logic [LPN_W-1:0] entry_lpn(logic [ENTRY_W-1:0] e, pg_size_e s);
        case (s)
            PG_4K:   return {e[11:10], e[22:12]};
            PG_8K:   return {1'b0, e[11:10], e[22:13]};
            PG_16K:  return {2'b0, e[11:10], e[22:14]};
            default: return {3'b0, e[11:10], e[22:15]};
        endcase
    endfunction

    // physical page held in an entry word: a size-dependent permutation
    function automatic logic [PPN_W-1:0] entry_ppn(logic [ENTRY_W-1:0] e, pg_size_e s);
        case (s)
            PG_4K:   return e[6:0];
            PG_8K:   return {e[0], e[6:1]};
            PG_16K:  return {e[1:0], e[6:2]};
            default: return {e[1], e[2], e[0], e[6:3]};
        endcase
    endfunction

    // logical page of a lookup address
    function automatic logic [LPN_W-1:0] addr_lpn(logic [LADDR_W-1:0] a, pg_size_e s);
        case (s)
            PG_4K:   return a[24:12];
            PG_8K:   return {1'b0, a[24:13]};
            PG_16K:  return {2'b0, a[24:14]};
            default: return {3'b0, a[24:15]};
        endcase
    endfunction

    // physical page joined with the in-page offset
    function automatic logic [PADDR_W-1:0] join_paddr(logic [PPN_W-1:0] p,
                                                      logic [LADDR_W-1:0] a,
                                                      pg_size_e s);
        case (s)
            PG_4K:   return {3'b0, p, a[11:0]};
            PG_8K:   return {2'b0, p, a[12:0]};
            PG_16K:  return {1'b0, p, a[13:0]};
            default: return {p, a[14:0]};
        endcase
    endfunction
endpackage

// File: rtl/xlat_table.sv
module xlat_table
    import xlat_pkg::*;
#(
    parameter int N_ENT = ENTRIES,
    parameter int EW    = ENTRY_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [EW-1:0]             wr_word,
    output logic [N_ENT-1:0][EW-1:0]  ent_o,
    output logic [N_ENT-1:0]          vld_o
);
    localparam int IW = $clog2(N_ENT);

    typedef struct packed {
        logic [N_ENT-1:0][EW-1:0] ent;
        logic [N_ENT-1:0]         vld;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    logic [IW-1:0] wr_idx;

    assign wr_idx = wr_word[IW-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_word;
            st_d.vld[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_o = st_q.ent;
    assign vld_o = st_q.vld;

    AST_WRITE_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_o[$past(wr_idx)]); // R2
    AST_WRITE_STORES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_o[$past(wr_idx)] == $past(wr_word)); // R2
endmodule

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N_ENT = ENTRIES,
    parameter int EW    = ENTRY_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  pg_size_e                  size,
    input  logic [LPN_W-1:0]          lk_lpn,
    input  logic [N_ENT-1:0][EW-1:0]  ent,
    input  logic [N_ENT-1:0]          vld,
    output logic                      hit,
    output logic [EW-1:0]             sel_ent
);
    logic [N_ENT-1:0] match;
    logic [N_ENT-1:0] grant;

    // one comparator per slot
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = vld[g] && (entry_lpn(ent[g], size) == lk_lpn);
    end

    // isolate the lowest set bit: lowest slot index wins
    assign grant = match & (~match + N_ENT'(1));
    assign hit   = |match;

    always_comb begin
        sel_ent = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (grant[i]) sel_ent = sel_ent | ent[i];
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R10
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant - N_ENT'(1)) & match) == '0); // R10
endmodule

// File: rtl/xlat_access.sv
module xlat_access
    import xlat_pkg::*;
(
    input  logic       hit,
    input  logic       user,
    input  logic       write,
    input  logic [1:0] prot,
    output logic       fault
);
    logic denied;

    always_comb begin
        denied = 1'b0;
        if (user) begin
            case (prot)
                2'd0:    denied = 1'b0;
                2'd1:    denied = write;
                default: denied = 1'b1;
            endcase
        end
        fault = !hit || denied;
    end
endmodule

// File: rtl/xlat_top.sv
module xlat_top
    import xlat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [3:2]          ctl_addr,
    input  logic                tbl_we,
    input  logic [ENTRY_W-1:0]  tbl_word,
    input  logic                lk_valid,
    input  logic [LADDR_W-1:0]  lk_addr,
    input  logic                lk_word,
    input  logic                lk_user,
    input  logic                lk_write,
    output logic                rs_valid,
    output logic                rs_hit,
    output logic                rs_fault,
    output logic [PADDR_W-1:0]  rs_paddr
);
    typedef struct packed {
        pg_size_e           size;
        logic               vld;
        logic               hit;
        logic               fault;
        logic [PADDR_W-1:0] paddr;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [ENTRIES-1:0][ENTRY_W-1:0] tbl_ent;
    logic [ENTRIES-1:0]              tbl_vld;
    logic [LADDR_W-1:0]              la;
    logic [LPN_W-1:0]                la_lpn;
    logic                            m_hit;
    logic [ENTRY_W-1:0]              m_ent;
    logic                            acc_fault;

    xlat_table #(.N_ENT(ENTRIES), .EW(ENTRY_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_word (tbl_word),
        .ent_o   (tbl_ent),
        .vld_o   (tbl_vld)
    );

    assign la     = lk_word ? {lk_addr[LADDR_W-1:2], 2'b00} : lk_addr;
    assign la_lpn = addr_lpn(la, st_q.size);

    xlat_match #(.N_ENT(ENTRIES), .EW(ENTRY_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .size    (st_q.size),
        .lk_lpn  (la_lpn),
        .ent     (tbl_ent),
        .vld     (tbl_vld),
        .hit     (m_hit),
        .sel_ent (m_ent)
    );

    xlat_access u_access (
        .hit   (m_hit),
        .user  (lk_user),
        .write (lk_write),
        .prot  (m_ent[PROT_LO+1:PROT_LO]),
        .fault (acc_fault)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = lk_valid;
        st_d.hit   = 1'b0;
        st_d.fault = 1'b0;
        st_d.paddr = '0;
        if (ctl_we) st_d.size = pg_size_e'(ctl_addr);
        if (lk_valid) begin
            st_d.hit   = m_hit;
            st_d.fault = acc_fault;
            if (m_hit) st_d.paddr = join_paddr(entry_ppn(m_ent, st_q.size), la, st_q.size);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{size: PG_4K, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rs_valid = st_q.vld;
    assign rs_hit   = st_q.hit;
    assign rs_fault = st_q.fault;
    assign rs_paddr = st_q.paddr;

    AST_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_fault && rs_paddr == '0)); // R9
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rs_valid && !rs_hit && !rs_fault)); // R12
    AST_SUPER_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_user && m_hit) |=> !rs_fault); // R11
    AST_SIZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(st_q.size)); // R7
endmodule

// File: tb/test_xlat_top.sv
module test_xlat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [3:2]  ctl_addr = '0;
    logic        tbl_we = 1'b0;
    logic [22:0] tbl_word = '0;
    logic        lk_valid = 1'b0;
    logic [24:0] lk_addr = '0;
    logic        lk_word = 1'b0;
    logic        lk_user = 1'b0;
    logic        lk_write = 1'b0;
    logic        rs_valid, rs_hit, rs_fault;
    logic [21:0] rs_paddr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [22:0] m_ent [128];
    bit          m_vld [128];
    int          m_size;

    bit          e_hit, e_fault;
    logic [21:0] e_paddr;

    always #5 clk = ~clk;

    xlat_top i_xlat_top (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .tbl_we(tbl_we), .tbl_word(tbl_word), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_word(lk_word), .lk_user(lk_user),
        .lk_write(lk_write), .rs_valid(rs_valid), .rs_hit(rs_hit),
        .rs_fault(rs_fault), .rs_paddr(rs_paddr)
    );

    function automatic logic [12:0] m_lpn(logic [22:0] e, int s);
        case (s)
            0: return {e[11:10], e[22:12]};                // R3
            1: return {1'b0, e[11:10], e[22:13]};          // R4
            2: return {2'b0, e[11:10], e[22:14]};          // R5
            default: return {3'b0, e[11:10], e[22:15]};    // R6
        endcase
    endfunction

    function automatic logic [6:0] m_ppn(logic [22:0] e, int s);
        case (s)
            0: return e[6:0];
            1: return {e[0], e[6:1]};
            2: return {e[1:0], e[6:2]};
            default: return {e[1], e[2], e[0], e[6:3]};
        endcase
    endfunction

    function automatic void model_lookup(logic [24:0] a_in, bit w, bit u, bit wr);
        logic [24:0] a;
        int sh, idx;
        bit found;
        logic [1:0] prot;
        a = w ? (a_in & ~25'h3) : a_in;                    // R8
        sh = 12 + m_size;
        found = 1'b0;
        idx = 0;
        for (int i = 0; i < 128; i++) begin
            if (!found && m_vld[i] && (m_lpn(m_ent[i], m_size) == 13'(a >> sh))) begin
                found = 1'b1;                              // R10 lowest index
                idx = i;
            end
        end
        e_hit = found;
        if (found) begin
            prot = m_ent[idx][9:8];
            e_paddr = 22'((32'(m_ppn(m_ent[idx], m_size)) << sh) | (32'(a) & ((32'd1 << sh) - 1)));
            e_fault = u && (prot >= 2 || (prot == 1 && wr)); // R11
        end else begin
            e_paddr = '0;                                  // R9
            e_fault = 1'b1;
        end
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: drive, predict, sample after the edge, then update the model
    task automatic step(bit twe, logic [22:0] tw, bit cwe, logic [1:0] csz,
                        bit lv, logic [24:0] la, bit lw, bit lu, bit lwr, string req);
        @(negedge clk);
        tbl_we = twe; tbl_word = tw; ctl_we = cwe; ctl_addr = csz;
        lk_valid = lv; lk_addr = la; lk_word = lw; lk_user = lu; lk_write = lwr;
        if (lv) model_lookup(la, lw, lu, lwr);
        @(posedge clk);
        #2;
        check(rs_valid == lv, "R12", "rs_valid", 32'(rs_valid), 32'(lv));
        if (lv) begin
            check({rs_hit, rs_fault, rs_paddr} == {e_hit, e_fault, e_paddr}, req,
                  "{hit,fault,paddr}", {8'h0, rs_hit, rs_fault, rs_paddr},
                  {8'h0, e_hit, e_fault, e_paddr});
        end else begin
            check({rs_hit, rs_fault, rs_paddr} == '0, "R12", "idle result",
                  {8'h0, rs_hit, rs_fault, rs_paddr}, 32'h0);
        end
        if (twe) begin
            m_ent[tw[6:0]] = tw;
            m_vld[tw[6:0]] = 1'b1;
        end
        if (cwe) m_size = int'(csz);
        tbl_we = 0; ctl_we = 0; lk_valid = 0;
    endtask

    task automatic look(logic [24:0] a, bit w, bit u, bit wr, string req);
        step(0, '0, 0, '0, 1, a, w, u, wr, req);
    endtask

    task automatic wr_ent(logic [22:0] e);
        step(1, e, 0, '0, 0, '0, 0, 0, 0, "R2");
    endtask

    task automatic set_size(logic [1:0] s);
        step(0, '0, 1, s, 0, '0, 0, 0, 0, "R7");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240313);
        for (int i = 0; i < 128; i++) begin
            m_vld[i] = 1'b0;
            m_ent[i] = '0;
        end
        m_size = 0;
        repeat (3) @(posedge clk);
        #2;
        check({rs_valid, rs_hit, rs_fault, rs_paddr} == '0, "R1", "reset outputs",
              {7'h0, rs_valid, rs_hit, rs_fault, rs_paddr}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        look(25'h0805123, 0, 0, 0, "R1");
        check(rs_fault && !rs_hit, "R1", "empty table fault", {30'h0, rs_hit, rs_fault}, 32'h1);

        // 4 KB directed
        wr_ent(23'h005423);
        look(25'h0805123, 0, 0, 0, "R3");
        check(rs_paddr == 22'h023123, "R3", "4K paddr", 32'(rs_paddr), 32'h023123);
        // duplicate logical page at lower index
        wr_ent(23'h005411);
        look(25'h0805123, 0, 0, 0, "R10");
        check(rs_paddr == 22'h011123, "R10", "lowest index wins", 32'(rs_paddr), 32'h011123);
        look(25'h0805127, 1, 0, 0, "R8");
        check(rs_paddr == 22'h011124, "R8", "word align", 32'(rs_paddr), 32'h011124);
        look(25'h0805127, 0, 0, 0, "R8");
        check(rs_paddr == 22'h011127, "R8", "byte offset", 32'(rs_paddr), 32'h011127);

        // table write and lookup in the same cycle
        step(1, 23'h007042, 0, '0, 1, 25'h0007abc, 0, 0, 0, "R12");
        check(!rs_hit, "R12", "same-cycle write unseen", 32'(rs_hit), 32'h0);
        look(25'h0007abc, 0, 0, 0, "R12");
        check(rs_hit && rs_paddr == 22'h042abc, "R12", "write seen next", 32'(rs_paddr), 32'h042abc);

        // protection levels
        wr_ent(23'h009106);
        look(25'h0009010, 0, 1, 0, "R11");
        check(rs_hit && !rs_fault, "R11", "lvl1 user read", {30'h0, rs_hit, rs_fault}, 32'h2);
        look(25'h0009010, 0, 1, 1, "R11");
        check(rs_hit && rs_fault, "R11", "lvl1 user write", {30'h0, rs_hit, rs_fault}, 32'h3);
        look(25'h0009010, 0, 0, 1, "R11");
        wr_ent(23'h009206);
        look(25'h0009010, 0, 1, 0, "R11");
        check(rs_fault, "R11", "lvl2 user read", 32'(rs_fault), 32'h1);
        look(25'h0009010, 0, 0, 0, "R11");
        wr_ent(23'h009306);
        look(25'h0009010, 0, 1, 0, "R11");

        // page size change in the same cycle as a lookup
        step(0, '0, 1, 2'd3, 1, 25'h0805123, 0, 0, 0, "R12");
        check(rs_paddr == 22'h011123, "R12", "old size used", 32'(rs_paddr), 32'h011123);
        look(25'h0805123, 0, 0, 0, "R7");
        wr_ent(23'h018805);
        look(25'h1019234, 0, 0, 0, "R6");
        check(rs_paddr == 22'h181234, "R6", "32K permuted ppn", 32'(rs_paddr), 32'h181234);
        set_size(2'd1);
        look(25'h1019234, 0, 0, 0, "R4");
        set_size(2'd2);
        look(25'h0805123, 0, 0, 0, "R5");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r, k;
            bit twe, cwe, lv;
            logic [22:0] tw;
            logic [24:0] la;
            string req;
            r = $urandom_range(0, 99);
            twe = (r < 15);
            cwe = ($urandom_range(0, 99) < 4);
            lv  = ($urandom_range(0, 99) < 85);
            tw  = 23'($urandom);
            if ($urandom_range(0, 3) != 0) tw[9:8] = 2'd0;
            la  = 25'($urandom);
            k = $urandom_range(0, 127);
            if (m_vld[k] && $urandom_range(0, 99) < 75) begin
                la = 25'((32'(m_lpn(m_ent[k], m_size)) << (12 + m_size)) |
                         ($urandom & ((32'd1 << (12 + m_size)) - 1)));
            end
            case (m_size)
                0: req = "R3";
                1: req = "R4";
                2: req = "R5";
                default: req = "R6";
            endcase
            step(twe, tw, cwe, 2'($urandom), lv, la, 1'($urandom), 1'($urandom),
                 1'($urandom), req);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule